// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port inside the chip and an external asynchronous static RAM of 512K bytes. The external part has a 19-bit address, an 8-bit data bus and active-low chip, write and output enables. Each request carries a direction flag, an address and a write byte. The sequencer turns it into one complete strobe cycle on the RAM pins. A read returns its byte on the response port with a one-cycle valid pulse.

The minimum nanosecond timings of the RAM are parameters. The block converts each of them to a whole number of clock cycles by rounding up, with at least one cycle per count. Writes are timed by the write enable, and the output enable stays high for the whole write, so write data goes onto the bus in the same cycle that the write enable falls. After every access, all strobes go high and the data driver switches off for a fixed recovery window. This window covers the time the RAM needs to release the bus and the minimum high time of the write enable. Between accesses the chip enable stays high, which keeps the RAM in its low-power standby state.

The data bus is brought out as three signals: an output value, an output enable and an input value. The tri-state pad sits at the chip edge.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the chip, write and output enables are high, the data driver enable is low and `req_ready` is high.
- R2: A read drives chip enable low, output enable low and write enable high. A write drives chip enable low, write enable low and output enable high. Write enable and output enable are never low together, and the address on the pins equals the accepted request address.
- R3: The read byte is sampled exactly RD = max(ceil(t_aa/P), ceil(t_rc/P), ceil(t_oe/P)) cycles after the strobes fall, where P is the clock period. With defaults RD is 10. At that point at least 100 ns have passed since chip enable and address, and at least 50 ns since output enable. The byte is presented with `rsp_valid` high for exactly one cycle, and it equals the byte last written to that location.
- R4: Write enable stays low for at least 60 ns. Chip enable stays low for at least 80 ns before the end of the write. The address is stable for at least 80 ns, and the write data is driven and stable for at least 40 ns, before write enable rises. Data and driver enable change in the same cycle as write enable and hold their values until it rises.
- R5: Write enable stays high for at least 5 ns between two writes, and successive write-enable falls are at least 100 ns apart. The write phase lasts WR = max of the rounded write counts including the cycle time, which is 10 cycles with defaults.
- R6: After each access, all strobes stay high and the driver stays off for REC = max(ceil(30/P), ceil(5/P)) cycles, which is 3 with defaults. The driver never turns on less than 30 ns after a read ends, and output enable never falls less than 30 ns after the driver turns off.
- R7: Chip enable is high whenever `req_ready` is high, so the RAM is in standby between accesses.
- R8: `req_ready` goes low on the edge that accepts a request and returns high exactly RD+REC cycles (reads) or WR+REC cycles (writes) later. A `req_valid` raised while `req_ready` is low is ignored, and the location it named keeps its contents.
- R9: The data driver enable is high only while a write is in progress, so the controller and the RAM never drive the bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 19 | RAM address pins |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 8 | Value for the data pads |
| sram_dq_oe | output | 1 | Data pad driver enable |
| sram_dq_i | input | 8 | Value read from the data pads |

## Verification
The sampling of read data and the release of all strobes into recovery happen on the same clock edge. Likewise, the end of a write and the switch-off of the data driver share one edge, which relies on the RAM's zero hold time. Both pairs are provoked by sweeping all locations of a small RAM model in back-to-back chains of write-read, read-read and write-write. A pin-level monitor timestamps every strobe edge and judges each sampling edge and each write end against the nanosecond minimums. The data returned is compared with a shadow copy kept by the bench. A request raised during the busy window of another access checks that acceptance and busy time never overlap.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RECOVER = 2'd2
  } seq_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_wdata,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_en,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o      <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      dq_oe     <= drive_en;
      rsp_valid <= capture;
      if (load_wdata) dq_o <= wdata;
      if (capture) rsp_data <= dq_i;
    end
  end

  // R3: response is a single-cycle pulse
  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4: write data does not move while it is being driven
  assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 100,
  parameter int T_RC_NS       = 100,
  parameter int T_OE_NS       = 50,
  parameter int T_WP_NS       = 60,
  parameter int T_CW_NS       = 80,
  parameter int T_AW_NS       = 80,
  parameter int T_DW_NS       = 40,
  parameter int T_WC_NS       = 100,
  parameter int T_WGAP_NS     = 5,
  parameter int T_HZ_NS       = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int RD_CYC = max_of(max_of(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_RC_NS, CLK_PERIOD_NS)),
                                 ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int WR_CYC = max_of(max_of(max_of(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_CW_NS, CLK_PERIOD_NS)),
                                        max_of(ns_to_cycles(T_AW_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_DW_NS, CLK_PERIOD_NS))),
                                 ns_to_cycles(T_WC_NS, CLK_PERIOD_NS));
  localparam int REC_CYC = max_of(ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS),
                                  ns_to_cycles(T_WGAP_NS, CLK_PERIOD_NS));
  localparam int LONGEST = max_of(max_of(RD_CYC, WR_CYC), REC_CYC);
  localparam int CNT_W   = $clog2(LONGEST + 1);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);

  seq_state_e       state_q, state_d;
  logic             is_wr_q;
  logic             ready_q;
  logic [ADDR_W-1:0] addr_q;
  logic             ce_n_q, we_n_q, oe_n_q;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             drive_d;
  logic             capture_d;
  logic             load_wdata;

  assign accept     = req_valid && ready_q;
  assign load_wdata = accept && req_write;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    drive_d   = 1'b0;
    capture_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_ACCESS;
          tmr_load = 1'b1;
          tmr_val  = req_write ? WR_LOAD : RD_LOAD;
          drive_d  = req_write;
        end
      end
      ST_ACCESS: begin
        if (tmr_expired) begin
          state_d   = ST_RECOVER;
          tmr_load  = 1'b1;
          tmr_val   = REC_LOAD;
          capture_d = !is_wr_q;
        end else begin
          drive_d = is_wr_q;
        end
      end
      ST_RECOVER: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_IDLE);
      if (state_q == ST_IDLE && accept) begin
        addr_q  <= req_addr;
        is_wr_q <= req_write;
        ce_n_q  <= 1'b0;
        we_n_q  <= !req_write;
        oe_n_q  <= req_write;
      end else if (state_q == ST_ACCESS && tmr_expired) begin
        ce_n_q <= 1'b1;
        we_n_q <= 1'b1;
        oe_n_q <= 1'b1;
      end
    end
  end

  sram_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_dq_path #(
    .DATA_W (DATA_W)
  ) u_dq (
    .clk        (clk),
    .rst        (rst),
    .load_wdata (load_wdata),
    .wdata      (req_wdata),
    .drive_en   (drive_d),
    .capture    (capture_d),
    .dq_i       (sram_dq_i),
    .dq_o       (sram_dq_o),
    .dq_oe      (sram_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_rdata)
  );

  assign req_ready = ready_q;
  assign sram_addr = addr_q;
  assign sram_ce_n = ce_n_q;
  assign sram_we_n = we_n_q;
  assign sram_oe_n = oe_n_q;

  // R2: write and output enable never low together
  assert_no_we_oe_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(!sram_we_n && !sram_oe_n));

  // R7: idle means the RAM is deselected
  assert_standby_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> sram_ce_n);

  // R4: address held for the whole selected window
  assert_addr_held_R4: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  // R9: driver only on during a write-enable-timed write
  assert_drive_only_in_write_R9: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_we_n && !sram_ce_n && sram_oe_n));

  // R8: accepting a request makes the port busy
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb;

  localparam int  CLK_PERIOD = 10;
  localparam int  ADDR_W = 19;
  localparam int  DATA_W = 8;
  localparam int  DEPTH  = 64;
  localparam int  RD_N   = (100 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int  WR_N   = (100 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int  REC_N  = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam real EPS    = 0.01;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] sram_addr;
  logic              sram_ce_n, sram_we_n, sram_oe_n;
  logic [DATA_W-1:0] sram_dq_o;
  logic              sram_dq_oe;
  logic [DATA_W-1:0] sram_dq_i;

  int    n_checks = 0;
  int    n_errors = 0;
  int    contention_cnt = 0;
  int    standby_viol = 0;
  longint cyc = 0;
  real   t_edge = 0.0;

  logic [DATA_W-1:0] stub_mem [DEPTH];
  logic [DATA_W-1:0] shadow   [DEPTH];
  logic              stub_drv;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  sram_seq_ctrl u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i)
  );

  // RAM stub: drives the bus while selected for reading
  assign stub_drv  = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign sram_dq_i = stub_drv ? stub_mem[sram_addr[5:0]] : 8'h00;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    t_edge = $realtime;
    cyc <= cyc + 1;
  end

  // Pin-level timing monitor
  real t_ce_fall = -1.0e6, t_we_fall = -1.0e6, t_we_rise = -1.0e6, t_oe_fall = -1.0e6;
  real t_addr_chg = -1.0e6, t_data_chg = -1.0e6, t_read_end = -1.0e6, t_drv_off = -1.0e6;
  bit  seen_wr = 0;
  logic p_ce = 1, p_we = 1, p_oe = 1, p_drv = 0;
  logic [ADDR_W-1:0] p_addr = '0;
  logic [DATA_W-1:0] p_dq = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!p_we && !p_ce && (sram_we_n || sram_ce_n)) begin
        chk(t_edge - t_we_fall >= 60.0 - EPS, "R4", "we low ns", longint'($rtoi(t_edge - t_we_fall)), 60);
        chk(t_edge - t_ce_fall >= 80.0 - EPS, "R4", "ce to write end ns", longint'($rtoi(t_edge - t_ce_fall)), 80);
        chk(t_edge - t_addr_chg >= 80.0 - EPS, "R4", "addr to write end ns", longint'($rtoi(t_edge - t_addr_chg)), 80);
        chk(p_drv && (t_edge - t_data_chg >= 40.0 - EPS), "R4", "data setup ns", longint'($rtoi(t_edge - t_data_chg)), 40);
        stub_mem[p_addr[5:0]] = p_dq;
        t_we_rise = t_edge;
      end
      if (p_we && !sram_we_n) begin
        chk(sram_oe_n == 1'b1, "R2", "oe high at write start", longint'(sram_oe_n), 1);
        if (seen_wr) begin
          chk(t_edge - t_we_rise >= 5.0 - EPS, "R5", "we high gap ns", longint'($rtoi(t_edge - t_we_rise)), 5);
          chk(t_edge - t_we_fall >= 100.0 - EPS, "R5", "write cycle ns", longint'($rtoi(t_edge - t_we_fall)), 100);
        end
        t_we_fall = t_edge;
        seen_wr = 1;
      end
      if (sram_addr != p_addr) t_addr_chg = t_edge;
      if (sram_dq_oe && (!p_drv || sram_dq_o != p_dq)) t_data_chg = t_edge;
      if (p_ce && !sram_ce_n) t_ce_fall = t_edge;
      if (!p_oe && sram_oe_n) t_read_end = t_edge;
      if (p_oe && !sram_oe_n) begin
        chk(t_edge - t_drv_off >= 30.0 - EPS, "R6", "driver off to oe low ns", longint'($rtoi(t_edge - t_drv_off)), 30);
        t_oe_fall = t_edge;
      end
      if (!p_drv && sram_dq_oe)
        chk(t_edge - t_read_end >= 30.0 - EPS, "R6", "read end to driver on ns", longint'($rtoi(t_edge - t_read_end)), 30);
      if (p_drv && !sram_dq_oe) t_drv_off = t_edge;
      if (rsp_valid) begin
        chk(t_edge - t_ce_fall >= 100.0 - EPS, "R3", "ce to sample ns", longint'($rtoi(t_edge - t_ce_fall)), 100);
        chk(t_edge - t_addr_chg >= 100.0 - EPS, "R3", "addr to sample ns", longint'($rtoi(t_edge - t_addr_chg)), 100);
        chk(t_edge - t_oe_fall >= 50.0 - EPS, "R3", "oe to sample ns", longint'($rtoi(t_edge - t_oe_fall)), 50);
      end
      if (sram_dq_oe && stub_drv) contention_cnt++;
      if (req_ready && !sram_ce_n) standby_viol++;
    end
    p_ce = sram_ce_n; p_we = sram_we_n; p_oe = sram_oe_n;
    p_drv = sram_dq_oe; p_addr = sram_addr; p_dq = sram_dq_o;
  end

  function automatic logic [DATA_W-1:0] pat(input int i, input int k);
    return DATA_W'(((i * 29) + 7 + (k * 53)) ^ (i >> 2));
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(input int i, input int k);
    return ADDR_W'(((k * 1237) << 6) | i);
  endfunction

  // Called and returning at a falling edge
  task automatic accept_req(input bit wr, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d, output longint acc);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    chk(req_ready == 1'b0, "R8", "ready low after accept", longint'(req_ready), 0);
    chk(sram_addr == a, "R2", "address on pins", longint'(sram_addr), longint'(a));
    chk(sram_ce_n == 1'b0 && sram_we_n == !wr && sram_oe_n == wr, "R2", "strobe mode {ce,we,oe}",
        longint'({sram_ce_n, sram_we_n, sram_oe_n}), longint'({1'b0, !wr, wr}));
    if (wr) chk(sram_dq_oe && sram_dq_o == d, "R4", "data driven with we fall",
                longint'({sram_dq_oe, sram_dq_o}), longint'({1'b1, d}));
  endtask

  task automatic wait_ready(input longint acc, input int n);
    while (!req_ready) @(negedge clk);
    chk(cyc - acc == n, "R8", "busy cycles", cyc - acc, n);
  endtask

  task automatic do_write(input int idx, input int k, input logic [DATA_W-1:0] d);
    longint acc;
    accept_req(1'b1, addr_of(idx, k), d, acc);
    shadow[idx] = d;
    wait_ready(acc, WR_N + REC_N);
  endtask

  task automatic do_read(input int idx, input int k);
    longint acc;
    accept_req(1'b0, addr_of(idx, k), '0, acc);
    while (!rsp_valid) @(negedge clk);
    chk(cyc - acc == RD_N, "R3", "read latency cycles", cyc - acc, RD_N);
    chk(rsp_rdata == shadow[idx], "R3", "read data", longint'(rsp_rdata), longint'(shadow[idx]));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R3", "valid single pulse", longint'(rsp_valid), 0);
    wait_ready(acc, RD_N + REC_N);
  endtask

  bit done = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      stub_mem[i] = 8'h00;
      shadow[i]   = 8'h00;
    end
    repeat (2) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1", "strobes in reset",
        longint'({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}), 14);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1", "strobes after reset",
        longint'({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}), 14);
    chk(req_ready == 1'b1, "R1", "ready after reset", longint'(req_ready), 1);

    // Sweep: write all, read all (different upper address bits)
    for (int i = 0; i < DEPTH; i++) do_write(i, 1, pat(i, 0));
    for (int i = 0; i < DEPTH; i++) do_read(i, 2);

    // Chains: write, read same, read next (R6 turnarounds in both directions)
    for (int i = 0; i < DEPTH; i++) begin
      do_write(i, 3, pat(i, 1));
      do_read(i, 4);
      do_read((i + 1) % DEPTH, 5);
    end

    // Back-to-back writes then reads (R5)
    for (int i = 0; i < 16; i++) do_write(i, 6, ~pat(i, 2));
    for (int i = 0; i < 16; i++) do_read(i, 7);

    // R8: request raised while busy is ignored
    begin
      longint acc;
      accept_req(1'b1, addr_of(9, 8), 8'h3C, acc);
      shadow[9] = 8'h3C;
      req_valid = 1'b1; req_write = 1'b1; req_addr = addr_of(10, 8); req_wdata = ~shadow[10];
      repeat (3) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R8", "busy while stray request", longint'(req_ready), 0);
      end
      req_valid = 1'b0;
      wait_ready(acc, WR_N + REC_N);
      do_read(10, 9);
      do_read(9, 9);
    end

    repeat (5) @(negedge clk);
    chk(contention_cnt == 0, "R9", "bus contention cycles", contention_cnt, 0);
    chk(standby_viol == 0, "R7", "ce low while idle", standby_viol, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000.0);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule